// File: doc/BRIEF.md
# Storage-to-Storage Byte Move Sequencer

This block carries out the move-character operation of a byte-addressed machine. It takes one 6-byte instruction that has already been fetched, over a valid/ready handshake. It splits the instruction into its opcode, length code and two base/displacement operands. It forms the destination and source addresses from the contents of the named base registers, which it reads through two combinational register-file read ports. It then copies the bytes over one byte-wide synchronous memory port, one at a time, in ascending address order.

A length code of L moves L+1 bytes, so a single instruction moves from 1 to 256 bytes. Each byte takes a read from the source address followed by a write to the destination address. The write finishes before the next read starts, so overlapping operands propagate bytes: a destination one above the source replicates the first byte.

The instruction input is valid/ready. The block raises `instr_ready` only while idle. An instruction held valid during a move waits, and it is not taken until the block is idle again. The memory port is request/ready: a request and its address, direction and write data stay fixed until the memory raises `mem_ready`. An opcode other than D2 (hex) gives a one-cycle illegal-operation pulse and touches no memory.

Top module: `ss_move_seq`

## Requirements
- R1: `instr_ready` is high only when the block is idle, that is, after reset and in the cycle after a done or illegal pulse. An instruction is taken only on a cycle with both `instr_valid` and `instr_ready` high. A word held valid while `instr_ready` is low is not taken.
- R2: The instruction word is big-endian: bits 47:40 hold the opcode, 39:32 the length code, 31:28 the destination base register number, 27:16 the destination displacement, 15:12 the source base register number and 11:0 the source displacement.
- R3: Each operand address is the low 24 bits of the named base register plus the zero-extended 12-bit displacement, modulo 2^24. Register number 0 contributes zero whatever that register holds, and the upper 8 bits of a register are ignored.
- R4: Length code L moves exactly L+1 bytes. Both addresses start at their operand address and rise by one per byte, wrapping modulo 2^24.
- R5: Every byte is one read handshake at the source address followed by one write handshake at the destination address, with the byte just read. The next read starts only after that write. Overlapping operands therefore see bytes written earlier in the same move.
- R6: Once `mem_req` is high, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold until a cycle with `mem_ready` high, which completes the transfer. Read data is taken from `mem_rdata` in that same cycle.
- R7: `done` is high for exactly one cycle, the cycle after the final write handshake. In the next cycle `instr_ready` is high again.
- R8: An opcode other than D2 (hex) makes `illegal_op` high for one cycle, the cycle after the instruction is taken. That instruction makes no memory request and gives no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Block idle and able to take an instruction |
| instr_word | input | 48 | Fetched instruction, big-endian |
| reg_idx_dst | output | 4 | Register number read for the destination base |
| reg_val_dst | input | 32 | Contents of register `reg_idx_dst` (combinational) |
| reg_idx_src | output | 4 | Register number read for the source base |
| reg_val_src | input | 32 | Contents of register `reg_idx_src` (combinational) |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the cycle `mem_ready` is high |
| mem_ready | input | 1 | Memory completes the current transfer |
| done | output | 1 | One-cycle pulse after the final write |
| illegal_op | output | 1 | One-cycle pulse for an opcode that is not a move |

## Verification
The bench builds the block with its default parameters: 24-bit addresses, 32-bit registers, an 8-bit length code and 4-bit base numbers with 12-bit displacements. With these values the full 256-byte move of the worked encoding D2FF 8001 7000 can be reached, and so can a move whose destination runs past address FFFFFF and wraps to zero. A base register with garbage in its top byte and a nonzero register 0 show that both are ignored. Random memory stalls and an instruction held valid during a busy move exercise both back-pressure paths.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DECODE = 3'd1,
    ST_READ   = 3'd2,
    ST_WRITE  = 3'd3,
    ST_DONE   = 3'd4
  } ssm_state_e;

  localparam logic [7:0] MOVE_OPCODE = 8'hD2;
endpackage

// File: rtl/ssm_decode.sv
module ssm_decode #(
  parameter int OPW = 8,
  parameter int LW  = 8,
  parameter int BW  = 4,
  parameter int DW  = 12,
  parameter logic [OPW-1:0] MOVE_OP = ssm_pkg::MOVE_OPCODE,
  localparam int IW = OPW + LW + 2 * (BW + DW)
) (
  input  logic [IW-1:0] instr,
  output logic          op_ok,
  output logic [LW-1:0] len_code,
  output logic [BW-1:0] dst_base,
  output logic [DW-1:0] dst_disp,
  output logic [BW-1:0] src_base,
  output logic [DW-1:0] src_disp
);
  localparam int SRC_D_LSB = 0;
  localparam int SRC_B_LSB = DW;
  localparam int DST_D_LSB = DW + BW;
  localparam int DST_B_LSB = 2 * DW + BW;
  localparam int LEN_LSB   = 2 * (DW + BW);
  localparam int OP_LSB    = LEN_LSB + LW;

  logic [OPW-1:0] opcode;

  assign opcode   = instr[OP_LSB    +: OPW];
  assign len_code = instr[LEN_LSB   +: LW];
  assign dst_base = instr[DST_B_LSB +: BW];
  assign dst_disp = instr[DST_D_LSB +: DW];
  assign src_base = instr[SRC_B_LSB +: BW];
  assign src_disp = instr[SRC_D_LSB +: DW];
  assign op_ok    = (opcode == MOVE_OP);
endmodule

// File: rtl/ssm_agen.sv
module ssm_agen #(
  parameter int AW = 24,
  parameter int RW = 32,
  parameter int BW = 4,
  parameter int DW = 12
) (
  input  logic [BW-1:0] base_idx,
  input  logic [RW-1:0] base_val,
  input  logic [DW-1:0] disp,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] base_eff;

  // register number zero means "no base"
  assign base_eff = (base_idx == '0) ? '0 : base_val[AW-1:0];
  assign addr     = base_eff + AW'(disp);

  generate
    if (RW > AW) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^base_val[RW-1:AW];
    end
  endgenerate
endmodule

// File: rtl/ssm_datapath.sv
module ssm_datapath #(
  parameter int AW  = 24,
  parameter int LW  = 8,
  parameter int BYW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [AW-1:0]  dst_init,
  input  logic [AW-1:0]  src_init,
  input  logic [LW-1:0]  len_init,
  input  logic           rd_take,
  input  logic           wr_take,
  input  logic [BYW-1:0] rdata,
  output logic [AW-1:0]  src_addr,
  output logic [AW-1:0]  dst_addr,
  output logic [BYW-1:0] hold_byte,
  output logic           last
);
  logic [LW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_addr <= '0;
      dst_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      src_addr <= src_init;
      dst_addr <= dst_init;
      remain   <= len_init;
    end else if (wr_take) begin
      src_addr <= src_addr + AW'(1);
      dst_addr <= dst_addr + AW'(1);
      remain   <= remain - LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_byte <= '0;
    end else if (rd_take) begin
      hold_byte <= rdata;
    end
  end

  assign last = (remain == '0);
endmodule

// File: rtl/ssm_ctrl.sv
module ssm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic instr_valid,
  input  logic op_ok,
  input  logic last,
  input  logic mem_ready,
  output logic instr_ready,
  output logic accept,
  output logic load,
  output logic rd_take,
  output logic wr_take,
  output logic mem_req,
  output logic mem_we,
  output logic done,
  output logic illegal_op
);
  import ssm_pkg::*;

  ssm_state_e state, state_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (accept) state_nx = ST_DECODE;
      ST_DECODE: state_nx = op_ok ? ST_READ : ST_IDLE;
      ST_READ:   if (mem_ready) state_nx = ST_WRITE;
      ST_WRITE:  if (mem_ready) state_nx = last ? ST_DONE : ST_READ;
      ST_DONE:   state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  assign instr_ready = (state == ST_IDLE);
  assign accept      = instr_valid && instr_ready;
  assign load        = (state == ST_DECODE) && op_ok;
  assign illegal_op  = (state == ST_DECODE) && !op_ok;
  assign mem_req     = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we      = (state == ST_WRITE);
  assign rd_take     = (state == ST_READ) && mem_ready;
  assign wr_take     = (state == ST_WRITE) && mem_ready;
  assign done        = (state == ST_DONE);
endmodule

// File: rtl/ss_move_seq.sv
module ss_move_seq #(
  parameter int AW  = 24,
  parameter int RW  = 32,
  parameter int LW  = 8,
  parameter int BW  = 4,
  parameter int DW  = 12,
  parameter int OPW = 8,
  parameter int BYW = 8,
  localparam int IW = OPW + LW + 2 * (BW + DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           instr_valid,
  output logic           instr_ready,
  input  logic [IW-1:0]  instr_word,
  output logic [BW-1:0]  reg_idx_dst,
  input  logic [RW-1:0]  reg_val_dst,
  output logic [BW-1:0]  reg_idx_src,
  input  logic [RW-1:0]  reg_val_src,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [BYW-1:0] mem_wdata,
  input  logic [BYW-1:0] mem_rdata,
  input  logic           mem_ready,
  output logic           done,
  output logic           illegal_op
);
  localparam int NOPND = 2;  // operand 0 = destination, 1 = source

  logic [IW-1:0]  instr_q;
  logic           accept, load, rd_take, wr_take, op_ok, last;
  logic [LW-1:0]  len_code;
  logic [BW-1:0]  base_idx [NOPND];
  logic [DW-1:0]  disp     [NOPND];
  logic [RW-1:0]  base_val [NOPND];
  logic [AW-1:0]  opnd_addr[NOPND];
  logic [AW-1:0]  src_addr, dst_addr;

  always_ff @(posedge clk) begin
    if (!rst_n)      instr_q <= '0;
    else if (accept) instr_q <= instr_word;
  end

  ssm_decode #(.OPW(OPW), .LW(LW), .BW(BW), .DW(DW)) u_dec (
    .instr    (instr_q),
    .op_ok    (op_ok),
    .len_code (len_code),
    .dst_base (base_idx[0]),
    .dst_disp (disp[0]),
    .src_base (base_idx[1]),
    .src_disp (disp[1])
  );

  assign reg_idx_dst = base_idx[0];
  assign reg_idx_src = base_idx[1];
  assign base_val[0] = reg_val_dst;
  assign base_val[1] = reg_val_src;

  generate
    for (genvar g = 0; g < NOPND; g++) begin : g_agen
      ssm_agen #(.AW(AW), .RW(RW), .BW(BW), .DW(DW)) u_agen (
        .base_idx (base_idx[g]),
        .base_val (base_val[g]),
        .disp     (disp[g]),
        .addr     (opnd_addr[g])
      );
    end
  endgenerate

  ssm_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .op_ok       (op_ok),
    .last        (last),
    .mem_ready   (mem_ready),
    .instr_ready (instr_ready),
    .accept      (accept),
    .load        (load),
    .rd_take     (rd_take),
    .wr_take     (wr_take),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .done        (done),
    .illegal_op  (illegal_op)
  );

  ssm_datapath #(.AW(AW), .LW(LW), .BYW(BYW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .dst_init  (opnd_addr[0]),
    .src_init  (opnd_addr[1]),
    .len_init  (len_code),
    .rd_take   (rd_take),
    .wr_take   (wr_take),
    .rdata     (mem_rdata),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .hold_byte (mem_wdata),
    .last      (last)
  );

  assign mem_addr = mem_we ? dst_addr : src_addr;
endmodule

// File: rtl/ssm_chk.sv
module ssm_chk #(
  parameter int AW  = 24,
  parameter int BYW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           instr_ready,
  input logic           mem_req,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [BYW-1:0] mem_wdata,
  input logic           mem_ready,
  input logic           done,
  input logic           illegal_op
);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  // R5
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we));

  // R5
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ready) |=> (done || (mem_req && !mem_we)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && instr_ready));

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> (!mem_req && !done && instr_ready));

  // R1
  busy_noaccept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || done || illegal_op) |-> !instr_ready);
endmodule

bind ss_move_seq ssm_chk #(.AW(AW), .BYW(BYW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_ready (instr_ready),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_ready   (mem_ready),
  .done        (done),
  .illegal_op  (illegal_op)
);

// File: tb/ss_move_seq_tb.sv
module ss_move_seq_tb;
  localparam int AW = 24;
  localparam logic [AW-1:0] AMASK = '1;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [7:0]    data;
  } acc_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        instr_valid = 0;
  logic        instr_ready;
  logic [47:0] instr_word = '0;
  logic [3:0]  reg_idx_dst, reg_idx_src;
  logic [31:0] reg_val_dst, reg_val_src;
  logic        mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ready = 0;
  logic        done, illegal_op;

  logic [31:0] regs [16];
  logic [7:0]  mem   [int unsigned];
  logic [7:0]  model [int unsigned];
  acc_t        exp_q [$];

  int n_chk = 0, n_fail = 0;
  int done_cnt = 0, ill_cnt = 0;
  bit stall_on = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  assign reg_val_dst = regs[reg_idx_dst];
  assign reg_val_src = regs[reg_idx_src];

  always #2 clk = ~clk;

  ss_move_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_word(instr_word),
    .reg_idx_dst(reg_idx_dst), .reg_val_dst(reg_val_dst),
    .reg_idx_src(reg_idx_src), .reg_val_src(reg_val_src),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .done(done), .illegal_op(illegal_op)
  );

  function automatic logic [7:0] rd_mem(int unsigned a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  function automatic logic [7:0] rd_model(int unsigned a);
    return model.exists(a) ? model[a] : 8'h00;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: memory responder and scoreboard, all on the falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ready = stall_on ? lfsr[0] : 1'b1;
      mem_rdata = rd_mem(int'(mem_addr));
      if (mem_req && mem_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4", "unexpected memory access", longint'(mem_addr), 0);
        end else begin
          acc_t e;
          e = exp_q.pop_front();
          chk(mem_we == e.we, "R5", "access direction", longint'(mem_we), longint'(e.we));
          chk(mem_addr == e.addr, "R4", "access address", longint'(mem_addr), longint'(e.addr));
          if (e.we)
            chk(mem_wdata == e.data, "R5", "write data", longint'(mem_wdata), longint'(e.data));
        end
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
      end
      if (done) begin
        done_cnt++;
        chk(exp_q.size() == 0, "R7", "done before final write", longint'(exp_q.size()), 0);
      end
      if (illegal_op) ill_cnt++;
    end
  end

  function automatic logic [AW-1:0] opnd(logic [3:0] b, logic [11:0] d);
    logic [AW-1:0] base;
    base = (b == 4'd0) ? '0 : regs[b][AW-1:0];
    return (base + AW'(d)) & AMASK;
  endfunction

  // driver: builds the expected access list, then issues the instruction
  task automatic run_move(logic [7:0] op, logic [7:0] len, logic [3:0] b1, logic [11:0] d1,
                          logic [3:0] b2, logic [11:0] d2, bit hold_next, string tag);
    logic [AW-1:0] s, d;
    logic [7:0] b;
    done_cnt = 0;
    ill_cnt  = 0;
    if (op == 8'hD2) begin
      model = mem;
      for (int i = 0; i <= int'(len); i++) begin
        s = (opnd(b2, d2) + AW'(i)) & AMASK;
        d = (opnd(b1, d1) + AW'(i)) & AMASK;
        b = rd_model(int'(s));
        model[int'(d)] = b;
        exp_q.push_back({1'b0, s, 8'h00});
        exp_q.push_back({1'b1, d, b});
      end
    end
    @(negedge clk);
    instr_word  = {op, len, b1, d1, b2, d2};
    instr_valid = 1;
    while (!instr_ready) @(negedge clk);
    @(negedge clk);
    if (hold_next) begin
      // R1: a second word is offered while busy; it must not be taken
      instr_word = {8'hD3, 8'h00, 4'h0, 12'h000, 4'h0, 12'h000};
      chk(instr_ready == 0, "R1", "ready while busy", longint'(instr_ready), 0);
    end else begin
      instr_valid = 0;
    end
    while (done_cnt == 0 && ill_cnt == 0) @(posedge clk);
    #1;
    instr_valid = 0;
    repeat (4) @(negedge clk);
    if (op == 8'hD2) begin
      chk(done_cnt == 1, "R7", "done pulse count", done_cnt, 1);
      chk(ill_cnt == 0, (hold_next ? "R1" : "R8"), "illegal pulse count", ill_cnt, 0);
    end else begin
      chk(ill_cnt == 1, "R8", "illegal pulse count", ill_cnt, 1);
      chk(done_cnt == 0, "R8", "done after illegal", done_cnt, 0);
    end
    chk(exp_q.size() == 0, tag, "accesses outstanding", longint'(exp_q.size()), 0);
    chk(instr_ready == 1, "R7", "ready after finish", longint'(instr_ready), 1);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #600000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(instr_ready == 1, "R1", "reset ready", longint'(instr_ready), 1);
    chk(mem_req == 0, "R6", "reset request", longint'(mem_req), 0);
    chk(done == 0, "R7", "reset done", longint'(done), 0);
    chk(illegal_op == 0, "R8", "reset illegal", longint'(illegal_op), 0);

    // R2, R4: single byte, distinct bases
    regs[3] = 32'h0000_0200;
    regs[4] = 32'h0000_0300;
    mem[32'h320] = 8'h5A;
    run_move(8'hD2, 8'h00, 4'd3, 12'h010, 4'd4, 12'h020, 0, "R2");
    chk(rd_mem(32'h210) == 8'h5A, "R2", "single byte result", longint'(rd_mem(32'h210)), 8'h5A);
    chk(rd_mem(32'h211) == 8'h00, "R4", "byte past length", longint'(rd_mem(32'h211)), 0);

    // R6, R1: 16 disjoint bytes with stalls and a held second instruction
    for (int i = 0; i < 16; i++) mem[32'h2000 + i] = 8'(8'h30 + i * 7);
    regs[9]  = 32'h0000_2000;
    regs[10] = 32'h0000_4000;
    stall_on = 1;
    run_move(8'hD2, 8'h0F, 4'd10, 12'h005, 4'd9, 12'h000, 1, "R6");

    // R5: worked encoding D2FF 8001 7000 with overlapping operands
    for (int i = 0; i < 257; i++) mem[32'h1000 + i] = 8'(i ^ 8'hC3);
    regs[7] = 32'h0000_1000;
    regs[8] = 32'h0000_1000;
    run_move(8'hD2, 8'hFF, 4'd8, 12'h001, 4'd7, 12'h000, 0, "R5");
    chk(rd_mem(32'h1100) == 8'hC3, "R5", "last replicated byte", longint'(rd_mem(32'h1100)), 8'hC3);

    // R3: register 0 means zero base even when it holds a value
    regs[0] = 32'h00AB_CDEF;
    for (int i = 0; i < 4; i++) mem[32'h200 + i] = 8'(8'h90 + i);
    run_move(8'hD2, 8'h03, 4'd0, 12'h100, 4'd0, 12'h200, 0, "R3");
    chk(rd_mem(32'h103) == 8'h93, "R3", "zero base result", longint'(rd_mem(32'h103)), 8'h93);

    // R3, R4: upper register byte ignored, destination wraps past FFFFFF
    regs[5] = 32'hA5FF_FFF0;
    regs[6] = 32'h0000_0400;
    for (int i = 0; i < 32; i++) mem[32'h400 + i] = 8'(8'h11 * i + 1);
    run_move(8'hD2, 8'h1F, 4'd5, 12'h008, 4'd6, 12'h000, 0, "R4");
    chk(rd_mem(32'h0) == 8'h89, "R4", "wrapped byte", longint'(rd_mem(32'h0)), 8'h89);

    // R8: wrong opcode
    stall_on = 0;
    run_move(8'hD3, 8'h05, 4'd3, 12'h000, 4'd4, 12'h000, 0, "R8");

    finish_run();
  end
endmodule